// File: doc/BRIEF.md
# External Memory Address Router

This block routes every data-memory access from the CPU to one of three places: on-chip XRAM, a 1 KB USB FIFO RAM window, or the off-chip bus. Each request carries an address, a read/write flag, write data and a width flag. The width flag says whether the address is a full 16-bit address or an 8-bit address whose upper byte has to be supplied separately. The block resolves the final 16-bit address and raises exactly one target select. It holds the routing configuration register and the bus port used to reach it.

On-chip and FIFO accesses complete in the cycle they are presented. An off-chip access stalls the CPU. The block captures the resolved address and data into a register, then holds an external request until the external bus sequencer reports done. The sequencer and both RAMs live outside the block.

Top module: `xmem_router`

## Requirements
- R1: The configuration register resets to 0x03. Bits 7 and 5 always read as zero, and writes to them are ignored, so writing 0xFF reads back as 0x5F. The fields are: bit 6 is the FIFO window enable, bits 3:2 are the routing mode, and bits 4 and 1:0 are stored with no routing effect.
- R2: In mode 00 every access goes on-chip, and the resolved address wraps modulo the on-chip RAM size (default 2048, so 0x1234 becomes 0x0234).
- R3: In modes 01 and 10, an address below the on-chip RAM size goes on-chip. An address equal to or above it goes off-chip.
- R4: In mode 01, an 8-bit access routed off-chip takes its upper byte from the address-high port latch input `port_hi`.
- R5: In mode 10, an 8-bit access routed off-chip takes its upper byte from the page input `page_hi`.
- R6: In mode 11 every access goes off-chip, and `ram_sel` never rises.
- R7: When bit 6 is set and `usb_clk_ok` is high, addresses 0x0400 to 0x07FF select the FIFO RAM in every mode. This takes priority over on-chip and off-chip routing, and the address passes through unchanged.
- R8: When `usb_clk_ok` is low, the FIFO window is closed, and the address is routed as if the window were disabled.
- R9: An 8-bit access takes its upper byte from `page_hi` to decide the route, and when the access resolves on-chip or to the FIFO, the same byte forms its resolved address.
- R10: An off-chip access raises `stall` in its first cycle with `ext_req` low. From the next cycle, `ext_req` is high and `res_addr` holds the resolved address. `stall` falls in the cycle `ext_done` is high, and `ext_req` is low in the cycle after that.
- R11: At most one of `ram_sel`, `fifo_sel` and `ext_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 8 | Configuration write value |
| cfg_rd_data | output | 8 | Configuration register read value |
| page_hi | input | 8 | Page register value, upper byte for 8-bit accesses |
| port_hi | input | 8 | Address-high port latch value |
| usb_clk_ok | input | 1 | High when the USB clock is at least twice the system clock |
| req_valid | input | 1 | Access request present, held while stall is high |
| req_wide | input | 1 | 1: 16-bit address; 0: 8-bit address in bits 7:0 |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| stall | output | 1 | Holds the CPU while an off-chip access is pending |
| ram_sel | output | 1 | On-chip XRAM select |
| fifo_sel | output | 1 | FIFO RAM select |
| ext_req | output | 1 | External bus request |
| ext_done | input | 1 | External sequencer completion |
| res_addr | output | 16 | Resolved address for the selected target |
| mem_we | output | 1 | Write flag accompanying the select |
| mem_wdata | output | 8 | Write data accompanying the select |

## Verification
Each mode is driven with addresses just below, at and far above the on-chip boundary, in both 16-bit and 8-bit form. Together these show how the boundary compare, the aliasing mask and the split decision behave. For 8-bit off-chip accesses, the page register and the port latch hold different values, so the resolved upper byte shows which source was used. FIFO addresses at both window edges are tried with the USB clock flag on and off, and in both split and external-only modes. This shows the window's priority and its gating.

// File: rtl/xmr_pkg.sv
package xmr_pkg;

  typedef enum logic [1:0] {
    MODE_LOCAL      = 2'b00,
    MODE_SPLIT_PORT = 2'b01,
    MODE_SPLIT_PAGE = 2'b10,
    MODE_REMOTE     = 2'b11
  } route_mode_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_RAM  = 2'b01,
    TGT_FIFO = 2'b10,
    TGT_EXT  = 2'b11
  } target_e;

  typedef struct packed {
    logic        fifo_en;
    route_mode_e mode;
  } route_cfg_t;

  localparam int CFG_FIFO_BIT = 6;
  localparam int CFG_MODE_LSB = 2;

endpackage

// File: rtl/xmr_rst_sync.sv
module xmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/xmr_cfg_reg.sv
module xmr_cfg_reg
  import xmr_pkg::*;
#(
  parameter logic [7:0] RESET_VAL  = 8'h03,
  parameter logic [7:0] WRITE_MASK = 8'h5F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output route_cfg_t cfg
);

  logic [7:0] cfg_q;
  logic [7:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d = wr_data & WRITE_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= RESET_VAL;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign rd_data     = cfg_q;
  assign cfg.fifo_en = cfg_q[CFG_FIFO_BIT];
  assign cfg.mode    = route_mode_e'(cfg_q[CFG_MODE_LSB +: 2]);

endmodule

// File: rtl/xmr_decode.sv
module xmr_decode
  import xmr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LO_W       = 8,
  parameter int RAM_BYTES  = 2048,
  parameter int FIFO_BASE  = 'h400,
  parameter int FIFO_BYTES = 1024
) (
  input  route_cfg_t              cfg,
  input  logic                    usb_clk_ok,
  input  logic [ADDR_W-LO_W-1:0]  page_hi,
  input  logic [ADDR_W-LO_W-1:0]  port_hi,
  input  logic                    wide,
  input  logic [ADDR_W-1:0]       addr,
  output target_e                 target,
  output logic [ADDR_W-1:0]       phys_addr
);

  localparam logic [ADDR_W:0]   RAM_LIMIT = (ADDR_W+1)'(RAM_BYTES);
  localparam logic [ADDR_W-1:0] RAM_MASK  = ADDR_W'(RAM_BYTES - 1);
  localparam logic [ADDR_W:0]   WIN_LO    = (ADDR_W+1)'(FIFO_BASE);
  localparam logic [ADDR_W:0]   WIN_HI    = (ADDR_W+1)'(FIFO_BASE + FIFO_BYTES);

  logic [ADDR_W-1:0] paged_addr;
  logic              below_ram;
  logic              in_window;
  logic              window_open;
  logic [ADDR_W-1:0] split_ext_addr;

  // 8-bit accesses classify with the page byte; wide ones use the full address
  always_comb begin
    if (wide) begin
      paged_addr = addr;
    end else begin
      paged_addr = {page_hi, addr[LO_W-1:0]};
    end
  end

  always_comb begin
    below_ram   = ({1'b0, paged_addr} < RAM_LIMIT);
    in_window   = ({1'b0, paged_addr} >= WIN_LO) && ({1'b0, paged_addr} < WIN_HI);
    window_open = cfg.fifo_en && usb_clk_ok && in_window;
  end

  // upper byte source for 8-bit off-chip traffic in the split modes
  always_comb begin
    if (wide) begin
      split_ext_addr = addr;
    end else if (cfg.mode == MODE_SPLIT_PORT) begin
      split_ext_addr = {port_hi, addr[LO_W-1:0]};
    end else begin
      split_ext_addr = {page_hi, addr[LO_W-1:0]};
    end
  end

  always_comb begin
    target    = TGT_NONE;
    phys_addr = paged_addr;
    if (window_open) begin
      target    = TGT_FIFO;
      phys_addr = paged_addr;
    end else begin
      unique case (cfg.mode)
        MODE_LOCAL: begin
          target    = TGT_RAM;
          phys_addr = paged_addr & RAM_MASK;
        end
        MODE_SPLIT_PORT, MODE_SPLIT_PAGE: begin
          if (below_ram) begin
            target    = TGT_RAM;
            phys_addr = paged_addr;
          end else begin
            target    = TGT_EXT;
            phys_addr = split_ext_addr;
          end
        end
        MODE_REMOTE: begin
          target    = TGT_EXT;
          phys_addr = paged_addr;
        end
        default: begin
          target    = TGT_NONE;
          phys_addr = paged_addr;
        end
      endcase
    end
  end

endmodule

// File: rtl/xmr_ext_fsm.sv
module xmr_ext_fsm #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              ext_done,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              we_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic              busy,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              lat_we,
  output logic [DATA_W-1:0] lat_wdata
);

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ext_state_e;

  ext_state_e        state_q, state_d;
  logic              cap_en;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (launch) begin
          state_d = ST_WAIT;
          cap_en  = 1'b1;
        end
      end
      ST_WAIT: begin
        if (ext_done) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (cap_en) begin
      addr_q  <= addr_in;
      we_q    <= we_in;
      wdata_q <= wdata_in;
    end
  end

  assign busy      = (state_q == ST_WAIT);
  assign lat_addr  = addr_q;
  assign lat_we    = we_q;
  assign lat_wdata = wdata_q;

endmodule

// File: rtl/xmem_router.sv
module xmem_router
  import xmr_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int RAM_BYTES   = 2048,
  parameter int FIFO_BASE   = 'h400,
  parameter int FIFO_BYTES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_wr_data,
  output logic [7:0]        cfg_rd_data,
  input  logic [7:0]        page_hi,
  input  logic [7:0]        port_hi,
  input  logic              usb_clk_ok,
  input  logic              req_valid,
  input  logic              req_wide,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              stall,
  output logic              ram_sel,
  output logic              fifo_sel,
  output logic              ext_req,
  input  logic              ext_done,
  output logic [ADDR_W-1:0] res_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata
);

  localparam int LO_W = ADDR_W - 8;

  logic              rst_n_int;
  route_cfg_t        cfg;
  target_e           target;
  logic [ADDR_W-1:0] phys_addr;
  logic              launch;
  logic              busy;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_we;
  logic [DATA_W-1:0] lat_wdata;

  xmr_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_int)
  );

  xmr_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_en  (cfg_wr_en),
    .wr_data(cfg_wr_data),
    .rd_data(cfg_rd_data),
    .cfg    (cfg)
  );

  xmr_decode #(
    .ADDR_W    (ADDR_W),
    .LO_W      (LO_W),
    .RAM_BYTES (RAM_BYTES),
    .FIFO_BASE (FIFO_BASE),
    .FIFO_BYTES(FIFO_BYTES)
  ) u_decode (
    .cfg       (cfg),
    .usb_clk_ok(usb_clk_ok),
    .page_hi   (page_hi),
    .port_hi   (port_hi),
    .wide      (req_wide),
    .addr      (req_addr),
    .target    (target),
    .phys_addr (phys_addr)
  );

  assign launch = req_valid && !busy && (target == TGT_EXT);

  xmr_ext_fsm #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ext (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .launch   (launch),
    .ext_done (ext_done),
    .addr_in  (phys_addr),
    .we_in    (req_write),
    .wdata_in (req_wdata),
    .busy     (busy),
    .lat_addr (lat_addr),
    .lat_we   (lat_we),
    .lat_wdata(lat_wdata)
  );

  always_comb begin
    ram_sel  = req_valid && !busy && (target == TGT_RAM);
    fifo_sel = req_valid && !busy && (target == TGT_FIFO);
    ext_req  = busy;
    stall    = launch || (busy && !ext_done);
    if (busy) begin
      res_addr  = lat_addr;
      mem_we    = lat_we;
      mem_wdata = lat_wdata;
    end else begin
      res_addr  = phys_addr;
      mem_we    = req_valid && req_write;
      mem_wdata = req_wdata;
    end
  end

endmodule

// File: rtl/xmr_checker.sv
module xmr_checker #(
  parameter int ADDR_W    = 16,
  parameter int RAM_BYTES = 2048
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cfg_rd_data,
  input logic              req_valid,
  input logic              req_wide,
  input logic [ADDR_W-1:0] req_addr,
  input logic              stall,
  input logic              ram_sel,
  input logic              fifo_sel,
  input logic              ext_req,
  input logic              ext_done,
  input logic [ADDR_W-1:0] res_addr
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(RAM_BYTES);

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data[7] == 1'b0) && (cfg_rd_data[5] == 1'b0));

  p_local_onchip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ext_req && !fifo_sel && cfg_rd_data[3:2] == 2'b00) |-> ram_sel);

  p_split_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ext_req && req_wide && ({1'b0, req_addr} < LIMIT) &&
     (cfg_rd_data[3:2] == 2'b01 || cfg_rd_data[3:2] == 2'b10)) |-> (ram_sel || fifo_sel));

  p_remote_no_ram_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data[3:2] == 2'b11) |-> !ram_sel);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_done) |=> (ext_req && $stable(res_addr)));

  p_req_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && ext_done) |=> !ext_req);

  p_stall_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> (stall == !ext_done));

  p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, fifo_sel, ext_req}));

endmodule

bind xmem_router xmr_checker #(
  .ADDR_W   (ADDR_W),
  .RAM_BYTES(RAM_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_rd_data(cfg_rd_data),
  .req_valid  (req_valid),
  .req_wide   (req_wide),
  .req_addr   (req_addr),
  .stall      (stall),
  .ram_sel    (ram_sel),
  .fifo_sel   (fifo_sel),
  .ext_req    (ext_req),
  .ext_done   (ext_done),
  .res_addr   (res_addr)
);

// File: tb/xmem_router_tb.sv
module xmem_router_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RAM_BYTES  = 2048;
  localparam int K_RAM  = 1;
  localparam int K_FIFO = 2;
  localparam int K_EXT  = 3;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [7:0]  cfg_wr_data;
  logic [7:0]  cfg_rd_data;
  logic [7:0]  page_hi;
  logic [7:0]  port_hi;
  logic        usb_clk_ok;
  logic        req_valid;
  logic        req_wide;
  logic        req_write;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        stall;
  logic        ram_sel;
  logic        fifo_sel;
  logic        ext_req;
  logic        ext_done;
  logic [15:0] res_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;

  typedef struct {
    int          kind;
    logic [15:0] addr;
    logic        we;
    logic [7:0]  wd;
    string       tag;
  } item_t;

  item_t sb[$];
  int    n_checks;
  int    n_fail;
  logic [7:0] cur_cfg;
  bit    done_flag;

  xmem_router u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .page_hi(page_hi), .port_hi(port_hi), .usb_clk_ok(usb_clk_ok),
    .req_valid(req_valid), .req_wide(req_wide), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .stall(stall), .ram_sel(ram_sel), .fifo_sel(fifo_sel), .ext_req(ext_req),
    .ext_done(ext_done), .res_addr(res_addr), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // expected routing derived from the requirements
  function automatic item_t model(input bit wide, input logic [15:0] a,
                                  input bit we, input logic [7:0] wd, input string tag);
    item_t it;
    logic [15:0] pg;
    logic [1:0]  mode;
    pg   = wide ? a : {page_hi, a[7:0]};
    mode = cur_cfg[3:2];
    it.we = we; it.wd = wd; it.tag = tag;
    if (cur_cfg[6] && usb_clk_ok && pg >= 16'h0400 && pg <= 16'h07FF) begin
      it.kind = K_FIFO; it.addr = pg;
    end else if (mode == 2'b00) begin
      it.kind = K_RAM; it.addr = pg % RAM_BYTES;
    end else if (mode == 2'b11) begin
      it.kind = K_EXT; it.addr = pg;
    end else if (pg < RAM_BYTES) begin
      it.kind = K_RAM; it.addr = pg;
    end else begin
      it.kind = K_EXT;
      it.addr = wide ? a : {(mode == 2'b01) ? port_hi : page_hi, a[7:0]};
    end
    return it;
  endfunction

  // external sequencer: done in the second cycle of the request
  initial begin
    int cnt;
    cnt = 0;
    ext_done = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (ext_req) cnt++;
      else cnt = 0;
      ext_done = (cnt == 2);
    end
  end

  // monitor: pops the scoreboard whenever a target completes
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (ram_sel || fifo_sel || (ext_req && ext_done))) begin
        int kind;
        kind = ram_sel ? K_RAM : (fifo_sel ? K_FIFO : K_EXT);
        if (sb.size() == 0) begin
          check(1'b0, "R11 unexpected select", kind, 0);
        end else begin
          item_t e;
          e = sb.pop_front();
          check(kind == e.kind, {e.tag, " target"}, kind, e.kind);
          check(res_addr == e.addr, {e.tag, " address"}, res_addr, e.addr);
          check(mem_we == e.we, {e.tag, " write flag"}, mem_we, e.we);
          if (e.we) check(mem_wdata == e.wd, {e.tag, " write data"}, mem_wdata, e.wd);
        end
      end
    end
  end

  task automatic set_cfg(input logic [7:0] v);
    @(posedge clk); #1;
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
    cur_cfg = v & 8'h5F;
  endtask

  task automatic access(input bit wide, input logic [15:0] a, input bit we,
                        input logic [7:0] wd, input string tag);
    item_t e;
    @(posedge clk); #1;
    req_valid = 1'b1; req_wide = wide; req_addr = a; req_write = we; req_wdata = wd;
    e = model(wide, a, we, wd, tag);
    sb.push_back(e);
    @(negedge clk);
    if (e.kind == K_EXT) begin
      check(stall && !ext_req, "R10 first cycle stall without request", {stall, ext_req}, 2'b10);
      while (stall) @(negedge clk);
    end else begin
      check(!stall, {tag, " no stall"}, stall, 0);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done_flag = 1'b0;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0; page_hi = '0; port_hi = '0;
    usb_clk_ok = 1'b0; req_valid = 1'b0; req_wide = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; cur_cfg = 8'h03;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(cfg_rd_data == 8'h03, "R1 reset value", cfg_rd_data, 8'h03);
    check(!ram_sel && !fifo_sel && !ext_req && !stall, "R10 idle after reset",
          {ram_sel, fifo_sel, ext_req, stall}, 0);

    set_cfg(8'hFF);
    @(negedge clk);
    check(cfg_rd_data == 8'h5F, "R1 reserved bits ignored", cfg_rd_data, 8'h5F);

    // mode 00: local only with aliasing
    set_cfg(8'h00);
    access(1'b1, 16'h1234, 1'b0, 8'h00, "R2 alias 0x1234");
    access(1'b1, 16'hFFFF, 1'b1, 8'hA5, "R2 alias top");
    page_hi = 8'h3A;
    access(1'b0, 16'h0055, 1'b0, 8'h00, "R9 page byte local");

    // mode 01: split, port latch for off-chip
    set_cfg(8'h04);
    access(1'b1, 16'h07FF, 1'b0, 8'h00, "R3 last on-chip");
    access(1'b1, 16'h0800, 1'b1, 8'h3C, "R3 first off-chip");
    page_hi = 8'h05; port_hi = 8'h9C;
    access(1'b0, 16'h0010, 1'b0, 8'h00, "R9 page byte split");
    page_hi = 8'h20;
    access(1'b0, 16'h0044, 1'b1, 8'h71, "R4 port latch byte");

    // mode 10: split, page register for off-chip
    set_cfg(8'h08);
    access(1'b0, 16'h0044, 1'b0, 8'h00, "R5 page byte off-chip");
    access(1'b1, 16'hC000, 1'b1, 8'h0F, "R3 wide off-chip");

    // mode 11: external only
    set_cfg(8'h0C);
    access(1'b1, 16'h0010, 1'b0, 8'h00, "R6 low address off-chip");
    page_hi = 8'h01;
    access(1'b0, 16'h0002, 1'b1, 8'hEE, "R6 narrow off-chip");

    // FIFO window
    usb_clk_ok = 1'b1;
    set_cfg(8'h44);
    access(1'b1, 16'h0400, 1'b1, 8'h11, "R7 window low edge");
    access(1'b1, 16'h07FF, 1'b0, 8'h00, "R7 window high edge");
    access(1'b1, 16'h03FF, 1'b0, 8'h00, "R7 below window");
    access(1'b1, 16'h0800, 1'b0, 8'h00, "R7 above window");
    set_cfg(8'h4C);
    access(1'b1, 16'h0500, 1'b0, 8'h00, "R7 window in external mode");
    page_hi = 8'h06;
    access(1'b0, 16'h0080, 1'b1, 8'h22, "R7 narrow window");
    set_cfg(8'h44);
    usb_clk_ok = 1'b0;
    access(1'b1, 16'h0400, 1'b0, 8'h00, "R8 window gated");
    set_cfg(8'h4C);
    access(1'b1, 16'h0600, 1'b0, 8'h00, "R8 gated external");

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R11 scoreboard drained", sb.size(), 0);
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done_flag) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule